// File: doc/BRIEF.md
# Invert-Capable Bit-Sliced Arithmetic Logic Unit

This block is an integer ALU built from a ripple chain of identical one-bit cells. Each cell can flip either of its operand bits. It then forms the AND, the OR and a full-adder sum of the two bits, and a four-way multiplexer picks the cell's output. Six operations come from this single cell:

- AND and OR.
- Addition.
- Subtraction: flip B and force the carry into bit 0 high.
- NOR: flip both operands and take the AND.
- Signed set-less-than: subtract, then route a corrected sign bit into bit 0 through the fourth multiplexer leg.

A 4-bit operation code drives the cells. Bit 3 flips A, bit 2 flips B, and bits 1:0 choose the multiplexer leg: 00 AND, 01 OR, 10 sum, 11 less. The carry into bit 0 equals the B-flip bit.

The result, a zero flag and an overflow flag are captured in an output register. The register loads when the clock enable is high, so results appear one clock after the operands are presented.

Top module: `alu_slice_top`

## Requirements
- R1: Code 0000 yields the bitwise AND of A and B.
- R2: Code 0001 yields the bitwise OR of A and B.
- R3: Code 0010 yields A plus B modulo 2^WIDTH.
- R4: Code 0110 yields A minus B modulo 2^WIDTH.
- R5: Code 1100 yields the bitwise NOR of A and B.
- R6: Code 0111 yields 1 in bit 0 when signed A is less than signed B, otherwise 0. This holds even when A minus B overflows. All upper bits are 0.
- R7: The zero flag is high exactly when every result bit is 0.
- R8: For codes 0010 and 0110, the overflow flag is high exactly when the signed sum or difference does not fit in WIDTH bits.
- R9: The outputs reflect the operands and code present at a rising clock edge where the enable is high. When the enable is low at an edge, the outputs keep their previous values.
- R10: While reset is active, the result is 0, the zero flag is 1 and the overflow flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the output register |
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| op_code | input | 4 | Operation: bit 3 flips A, bit 2 flips B, bits 1:0 choose the leg |
| result_q | output | WIDTH | Registered result |
| zero_q | output | 1 | Registered zero flag |
| ovf_q | output | 1 | Registered signed overflow flag |

## Verification
The bench builds the block with WIDTH = 32, the default. At this width the most-negative and most-positive operands sit at the sign boundary, so it can be probed directly, and a carry can ripple across every cell, for example all-ones plus one. These operands reach the overflow cases of both addition and subtraction. They also reach the set-less-than cases where the raw difference sign is wrong and must be corrected. A scrambled sweep over all six codes adds broad coverage, and enable-low cycles confirm that the outputs hold.

// File: rtl/alu_slice_pkg.sv
`timescale 1ns/1ps
package alu_slice_pkg;
  typedef enum logic [1:0] {
    LEG_AND  = 2'b00,
    LEG_OR   = 2'b01,
    LEG_SUM  = 2'b10,
    LEG_LESS = 2'b11
  } leg_e;

  typedef struct packed {
    logic flip_a;
    logic flip_b;
    leg_e leg;
  } ctrl_t;
endpackage

// File: rtl/alu_bit_cell.sv
`timescale 1ns/1ps
module alu_bit_cell
  import alu_slice_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic flip_a_i,
  input  logic flip_b_i,
  input  logic carry_i,
  input  logic less_i,
  input  leg_e leg_i,
  output logic res_o,
  output logic carry_o
);
  logic a_eff, b_eff, sum_w;

  always_comb begin
    a_eff   = a_i ^ flip_a_i;
    b_eff   = b_i ^ flip_b_i;
    sum_w   = a_eff ^ b_eff ^ carry_i;
    carry_o = (a_eff & b_eff) | (a_eff & carry_i) | (b_eff & carry_i);
    unique case (leg_i)
      LEG_AND:  res_o = a_eff & b_eff;
      LEG_OR:   res_o = a_eff | b_eff;
      LEG_SUM:  res_o = sum_w;
      default:  res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_ripple_chain.sv
`timescale 1ns/1ps
module alu_ripple_chain
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  ctrl_t            ctrl_i,
  output logic [WIDTH-1:0] res_o,
  output logic             msb_carry_in_o,
  output logic             msb_carry_out_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;
  logic           set_bit;

  assign carry[0] = ctrl_i.flip_b;

  // corrected sign of the difference: raw msb sum xor overflow reduces to this
  assign set_bit = (a_i[MSB] ^ ctrl_i.flip_a) ^ (b_i[MSB] ^ ctrl_i.flip_b) ^ carry[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    alu_bit_cell u_cell (
      .a_i      (a_i[i]),
      .b_i      (b_i[i]),
      .flip_a_i (ctrl_i.flip_a),
      .flip_b_i (ctrl_i.flip_b),
      .carry_i  (carry[i]),
      .less_i   ((i == 0) ? set_bit : 1'b0),
      .leg_i    (ctrl_i.leg),
      .res_o    (res_o[i]),
      .carry_o  (carry[i+1])
    );
  end

  assign msb_carry_in_o  = carry[MSB];
  assign msb_carry_out_o = carry[WIDTH];
endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
module alu_flag_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             msb_carry_in_i,
  input  logic             msb_carry_out_i,
  output logic             zero_o,
  output logic             ovf_o
);
  assign zero_o = ~(|res_i);
  assign ovf_o  = msb_carry_in_i ^ msb_carry_out_i;
endmodule

// File: rtl/alu_slice_top.sv
`timescale 1ns/1ps
module alu_slice_top
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] result_q,
  output logic             zero_q,
  output logic             ovf_q
);
  ctrl_t            ctrl;
  logic [WIDTH-1:0] res_c;
  logic             cin_msb, cout_msb, zero_c, ovf_c;
  logic [WIDTH-1:0] result_d;
  logic             zero_d, ovf_d;

  assign ctrl.flip_a = op_code[3];
  assign ctrl.flip_b = op_code[2];
  assign ctrl.leg    = leg_e'(op_code[1:0]);

  alu_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i             (opnd_a),
    .b_i             (opnd_b),
    .ctrl_i          (ctrl),
    .res_o           (res_c),
    .msb_carry_in_o  (cin_msb),
    .msb_carry_out_o (cout_msb)
  );

  alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .res_i           (res_c),
    .msb_carry_in_i  (cin_msb),
    .msb_carry_out_i (cout_msb),
    .zero_o          (zero_c),
    .ovf_o           (ovf_c)
  );

  always_comb begin
    result_d = result_q;
    zero_d   = zero_q;
    ovf_d    = ovf_q;
    if (en) begin
      result_d = res_c;
      zero_d   = zero_c;
      ovf_d    = ovf_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      zero_q   <= 1'b1;
      ovf_q    <= 1'b0;
    end else begin
      result_q <= result_d;
      zero_q   <= zero_d;
      ovf_q    <= ovf_d;
    end
  end
endmodule

// File: rtl/alu_slice_chk.sv
`timescale 1ns/1ps
module alu_slice_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] result_q,
  input logic             zero_q,
  input logic             ovf_q
);
  // R1
  and_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code == 4'b0000) |=> result_q == $past(opnd_a & opnd_b));

  // R3
  add_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code == 4'b0010) |=> result_q == $past(opnd_a + opnd_b));

  // R5
  nor_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code == 4'b1100) |=> result_q == $past(~(opnd_a | opnd_b)));

  // R6
  less_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code == 4'b0111) |=> result_q[WIDTH-1:1] == '0);

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q == (result_q == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result_q) && $stable(zero_q) && $stable(ovf_q)));
endmodule

bind alu_slice_top alu_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .op_code  (op_code),
  .result_q (result_q),
  .zero_q   (zero_q),
  .ovf_q    (ovf_q)
);

// File: tb/alu_slice_top_bench.sv
`timescale 1ns/1ps
module alu_slice_top_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic [W-1:0] opnd_a, opnd_b;
  logic [3:0]   op_code;
  logic [W-1:0] result_q;
  logic         zero_q, ovf_q;

  typedef struct {
    logic [W-1:0] res;
    logic         z;
    logic         v;
    logic         chk_v;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last;
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #2 clk = ~clk;

  alu_slice_top #(.WIDTH(W)) u_alu_slice_top (
    .clk(clk), .rst_n(rst_n), .en(en), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .op_code(op_code), .result_q(result_q), .zero_q(zero_q), .ovf_q(ovf_q)
  );

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic [3:0] op, input string tag);
    exp_t e;
    e.tag   = tag;
    e.chk_v = 1'b0;
    e.v     = 1'b0;
    case (op)
      4'b0000: e.res = a & b;
      4'b0001: e.res = a | b;
      4'b0010: begin
        e.res = a + b; e.chk_v = 1'b1;
        e.v = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
      end
      4'b0110: begin
        e.res = a - b; e.chk_v = 1'b1;
        e.v = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
      end
      4'b0111: e.res = ($signed(a) < $signed(b)) ? {{(W-1){1'b0}}, 1'b1} : '0;
      default: e.res = ~(a | b);
    endcase
    e.z = (e.res == '0);
    return e;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] op, input bit e, input string tag);
    @(negedge clk);
    opnd_a  = a;
    opnd_b  = b;
    op_code = op;
    en      = e;
    if (e) last = model(a, b, op, tag);
    else   last.tag = tag;
    exp_q.push_back(last);
  endtask

  // monitor: each rising edge consumes one queued expectation
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && exp_q.size() > 0) begin
        exp_t x;
        #1;
        x = exp_q.pop_front();
        n_vec++;
        if (result_q !== x.res || zero_q !== x.z || (x.chk_v && ovf_q !== x.v)) begin
          n_fail++;
          $display("FAIL %s: got res=%h z=%b v=%b, expected res=%h z=%b v=%b",
                   x.tag, result_q, zero_q, ovf_q, x.res, x.z, x.v);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    rst_n = 1'b0; en = 1'b0; opnd_a = '0; opnd_b = '0; op_code = '0;
    repeat (3) @(negedge clk);
    // R10 reset values
    n_vec++;
    if (result_q !== '0 || zero_q !== 1'b1 || ovf_q !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: got res=%h z=%b v=%b, expected res=0 z=1 v=0", result_q, zero_q, ovf_q);
    end
    last = '{res: '0, z: 1'b1, v: 1'b0, chk_v: 1'b0, tag: "R10"};
    rst_n = 1'b1;

    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000, 1, "R1 and");
    drive(32'hAAAA_0000, 32'h5555_0000, 4'b0000, 1, "R7 and zero");
    drive(32'hF000_0001, 32'h0F00_0002, 4'b0001, 1, "R2 or");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, 1, "R8 add overflow");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, 1, "R3 add full carry");
    drive(32'h0000_0005, 32'h0000_0009, 4'b0110, 1, "R4 sub negative");
    drive(32'h8000_0000, 32'h0000_0001, 4'b0110, 1, "R8 sub overflow");
    drive(32'h1234_5678, 32'h1234_5678, 4'b0110, 1, "R7 sub equal");
    drive(32'h0F0F_0000, 32'h00FF_0000, 4'b1100, 1, "R5 nor");
    drive(32'h8000_0000, 32'h0000_0001, 4'b0111, 1, "R6 less overflow true");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111, 1, "R6 less overflow false");
    drive(32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'b0111, 1, "R6 less negatives");
    drive(32'h0000_0003, 32'h0000_0003, 4'b0111, 1, "R6 less equal");
    drive(32'h0000_0001, 32'h0000_0002, 4'b0111, 0, "R9 hold");
    drive(32'hDEAD_BEEF, 32'h1111_1111, 4'b0010, 0, "R9 hold");

    lfsr = 32'hACE1_2025;
    for (int i = 0; i < 240; i++) begin
      logic [W-1:0] a, b;
      logic [3:0]   op;
      lfsr = {lfsr[W-2:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[W-2:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = (i % 7 == 0) ? a : lfsr;
      case (i % 6)
        0: op = 4'b0000;
        1: op = 4'b0001;
        2: op = 4'b0010;
        3: op = 4'b0110;
        4: op = 4'b0111;
        default: op = 4'b1100;
      endcase
      drive(a, b, op, (i % 11 != 5), "R3 R4 R6 R8 sweep");
    end

    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule